// File: doc/BRIEF.md
# Low-Power Timer Start and Reset Control

This block is the control and counting core of a low-power timer. A 32-bit control word, written and read from the bus side, holds an enable bit and four request bits. Once the timer is enabled, software can ask for a one-shot count or a continuous count, clear the counter, or make every counter read also clear the counter. The counter steps once per clock from 0 up to an auto-reload value. In continuous mode it then wraps to 0. In one-shot mode it stops at 0. A one-cycle match pulse marks the cycle in which the counter equals the reload value.

A start request begins counting at once when the trigger selection is 00. With any other trigger selection, the request only arms the timer, and counting begins on the next rising edge of the external trigger. A new start request given while the counter runs changes the mode of the running count, and this takes effect at the next reload match. A counter-reset request passes through a fixed three-stage synchronizing pipeline before it clears the counter. Its bit stays visible to software until the clear has happened. Clearing the enable bit stops everything on the write edge.

Top module: `lptimCtl`

## Requirements
- R1: The control word uses these fields: bit 0 enable, bit 1 single start, bit 2 continuous start, bit 3 counter reset, bit 4 reset-after-read. Bits 31:5 read 0. After reset the whole word reads 0, the counter is 0 and `running` is low.
- R2: A write of 1 to any of bits 4:1 takes effect only if enable was already 1 before that write. Otherwise the bit stays 0.
- R3: With `trigSel` = 00, an accepted start request sets `running` high in the cycle after the request bit is set. From 0, the counter then increments once per clock.
- R4: With `trigSel` other than 00, a start request only arms the timer, and `running` stays low. A rising edge on `extTrig`, sampled at a clock edge, sets `running` high after that edge, with the counter at 0.
- R5: In continuous mode, `matchPulse` is high while the counter equals `reloadVal`. The counter is 0 after the next edge, and counting goes on.
- R6: In one-shot mode, `matchPulse` is high while the counter equals `reloadVal`. After the next edge the counter is 0 and `running` is low.
- R7: A continuous-start request accepted during a one-shot count makes the counter wrap at the next match instead of stopping.
- R8: A single-start request accepted during a continuous count makes the counter stop at the next match.
- R9: A start bit reads 1 for one cycle after it is set and is cleared when the request is accepted. If both start bits are set together, continuous mode is taken.
- R10: After a write that sets the counter-reset bit, the bit reads 1 for the next two cycles, while the counter keeps counting. On the third clock edge after the write edge, the counter becomes 0 and the bit clears.
- R11: With reset-after-read set, a cycle with `cntRdEn` high returns the current count on `cntRdData`, and the counter is 0 after that edge.
- R12: A write with bit 0 = 0 clears, on its own edge, the counter, `running`, and bits 4:1 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the counter |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word write data |
| ctrlRdData | output | 32 | Control word read value |
| cntRdEn | input | 1 | Counter read strobe (drives reset-after-read) |
| cntRdData | output | CNT_W | Current counter value |
| reloadVal | input | CNT_W | Auto-reload value |
| trigSel | input | 2 | 00 = software start; any other value = start on the rising edge of extTrig |
| extTrig | input | 1 | External trigger, sampled synchronously |
| running | output | 1 | High while the counter is counting |
| matchPulse | output | 1 | High in the cycle where the running count equals reloadVal |

## Verification
The bound checker checks these properties on every cycle: reserved bits read 0; a disabled timer has a zero counter, `running` low and no pending request bits; a start bit clears one cycle after it rises; a counter-reset bit stays set for at least one cycle after it rises; the counter is 0 right after a match; and a match pulse lasts one cycle. The bench's directed scenarios cover the behaviour that depends on ordering and exact latency: the cycle on which counting starts with and without a trigger, the switch from one-shot to continuous and back in the middle of a count, the third-edge timing of the counter reset, and clear-on-read.

// File: rtl/lptimCtlPkg.sv
package lptimCtlPkg;

  localparam int BIT_EN   = 0;
  localparam int BIT_SNG  = 1;
  localparam int BIT_CONT = 2;
  localparam int BIT_CRST = 3;
  localparam int BIT_RAR  = 4;
  localparam int CTRL_W   = 32;
  localparam int CTRL_USED = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seqState_e;

  typedef struct packed {
    logic clear;
    logic step;
  } cntStrobe_t;

endpackage

// File: rtl/lptimCtlRegs.sv
module lptimCtlRegs
  import lptimCtlPkg::*;
#(
  parameter int RST_SYNC = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [CTRL_USED-1:0]  wrData,
  input  logic                  sngAck,
  input  logic                  contAck,
  output logic                  enable,
  output logic                  sngReq,
  output logic                  contReq,
  output logic                  crstReq,
  output logic                  rarEn,
  output logic                  killNow,
  output logic                  crstFire,
  output logic [CTRL_W-1:0]     rdData
);

  logic                accept;
  logic [RST_SYNC-1:0] crstPipe;

  assign killNow  = wrEn & ~wrData[BIT_EN];
  assign accept   = wrEn & enable;
  assign crstFire = crstPipe[RST_SYNC-2] & ~crstPipe[RST_SYNC-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      sngReq   <= 1'b0;
      contReq  <= 1'b0;
      crstReq  <= 1'b0;
      rarEn    <= 1'b0;
      crstPipe <= '0;
    end else begin
      if (wrEn) enable <= wrData[BIT_EN];
      if (killNow) begin
        sngReq   <= 1'b0;
        contReq  <= 1'b0;
        crstReq  <= 1'b0;
        rarEn    <= 1'b0;
        crstPipe <= '0;
      end else begin
        sngReq   <= (sngReq & ~sngAck) | (accept & wrData[BIT_SNG]);
        contReq  <= (contReq & ~contAck) | (accept & wrData[BIT_CONT]);
        crstReq  <= (crstReq & ~crstFire) | (accept & wrData[BIT_CRST] & ~crstReq);
        if (accept) rarEn <= wrData[BIT_RAR];
        crstPipe <= {crstPipe[RST_SYNC-2:0], crstReq};
      end
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[BIT_EN]   = enable;
    rdData[BIT_SNG]  = sngReq;
    rdData[BIT_CONT] = contReq;
    rdData[BIT_CRST] = crstReq;
    rdData[BIT_RAR]  = rarEn;
  end

endmodule

// File: rtl/lptimCtlSeq.sv
module lptimCtlSeq
  import lptimCtlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       killNow,
  input  logic       sngReq,
  input  logic       contReq,
  input  logic       crstFire,
  input  logic       rdClear,
  input  logic [1:0] trigSel,
  input  logic       extTrig,
  input  logic       atMatch,
  output cntStrobe_t strobe,
  output logic       running,
  output logic       matchPulse,
  output logic       sngAck,
  output logic       contAck
);

  seqState_e state, stateNext;
  logic      oneShot, oneShotNext;
  logic      trigQ, trigRise, killAll, anyReq, swStart;

  assign killAll  = killNow | ~enable;
  assign anyReq   = sngReq | contReq;
  assign trigRise = extTrig & ~trigQ;
  assign swStart  = (trigSel == 2'b00);

  always_comb begin
    stateNext    = state;
    oneShotNext  = oneShot;
    sngAck       = 1'b0;
    contAck      = 1'b0;
    strobe       = '0;
    matchPulse   = 1'b0;
    if (killAll) begin
      stateNext    = SEQ_IDLE;
      oneShotNext  = 1'b0;
      strobe.clear = 1'b1;
    end else begin
      if (anyReq) begin
        sngAck      = sngReq;
        contAck     = contReq;
        oneShotNext = ~contReq;
      end
      unique case (state)
        SEQ_IDLE: begin
          if (anyReq) stateNext = swStart ? SEQ_RUN : SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (trigRise) stateNext = SEQ_RUN;
        end
        SEQ_RUN: begin
          if (atMatch) begin
            matchPulse   = 1'b1;
            strobe.clear = 1'b1;
            if (oneShotNext) stateNext = SEQ_IDLE;
          end else begin
            strobe.step = 1'b1;
          end
        end
        default: stateNext = SEQ_IDLE;
      endcase
      if (crstFire | rdClear) strobe.clear = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      oneShot <= 1'b0;
      trigQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      oneShot <= oneShotNext;
      trigQ   <= extTrig;
    end
  end

  assign running = (state == SEQ_RUN);

endmodule

// File: rtl/lptimCtlCount.sv
module lptimCtlCount
  import lptimCtlPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             atMatch
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobe.clear) count <= '0;
    else if (strobe.step)  count <= count + 1'b1;
  end

  assign atMatch = (count == reloadVal);

endmodule

// File: rtl/lptimCtl.sv
module lptimCtl
  import lptimCtlPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RST_SYNC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [31:0]      ctrlWrData,
  output logic [31:0]      ctrlRdData,
  input  logic             cntRdEn,
  output logic [CNT_W-1:0] cntRdData,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [1:0]       trigSel,
  input  logic             extTrig,
  output logic             running,
  output logic             matchPulse
);

  logic       enable, sngReq, contReq, crstReq, rarEn;
  logic       killNow, crstFire, sngAck, contAck, atMatch, rdClear;
  logic       unusedWrHi;
  cntStrobe_t strobe;

  assign unusedWrHi = ^ctrlWrData[CTRL_W-1:CTRL_USED] ^ crstReq;
  assign rdClear    = cntRdEn & rarEn & enable;

  lptimCtlRegs #(.RST_SYNC(RST_SYNC)) regs_i (
    .clk(clk), .rstN(rstN),
    .wrEn(ctrlWrEn), .wrData(ctrlWrData[CTRL_USED-1:0]),
    .sngAck(sngAck), .contAck(contAck),
    .enable(enable), .sngReq(sngReq), .contReq(contReq),
    .crstReq(crstReq), .rarEn(rarEn),
    .killNow(killNow), .crstFire(crstFire), .rdData(ctrlRdData)
  );

  lptimCtlSeq seq_i (
    .clk(clk), .rstN(rstN),
    .enable(enable), .killNow(killNow),
    .sngReq(sngReq), .contReq(contReq),
    .crstFire(crstFire), .rdClear(rdClear),
    .trigSel(trigSel), .extTrig(extTrig), .atMatch(atMatch),
    .strobe(strobe), .running(running), .matchPulse(matchPulse),
    .sngAck(sngAck), .contAck(contAck)
  );

  lptimCtlCount #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reloadVal(reloadVal),
    .count(cntRdData), .atMatch(atMatch)
  );

endmodule

// File: rtl/lptimCtlChk.sv
module lptimCtlChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrEn,
  input logic [31:0]      ctrlWrData,
  input logic [31:0]      ctrlRdData,
  input logic [CNT_W-1:0] cntRdData,
  input logic [CNT_W-1:0] reloadVal,
  input logic             running,
  input logic             matchPulse
);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[31:5] == 27'd0);

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[0] |-> (ctrlRdData[4:1] == 4'd0 && !running && cntRdData == '0));

  p_start_selfclear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlRdData[1]) && !ctrlWrEn) |=> !ctrlRdData[1]);

  p_crst_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlRdData[3]) && !ctrlWrEn) |=> ctrlRdData[3]);

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> cntRdData == '0);

  p_match_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && reloadVal != '0) |=> (!matchPulse || reloadVal == '0));

endmodule

bind lptimCtl lptimCtlChk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/lptimCtl_tb_top.sv
module lptimCtl_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [31:0]   ctrlWrData = '0;
  logic [31:0]   ctrlRdData;
  logic          cntRdEn = 1'b0;
  logic [CW-1:0] cntRdData;
  logic [CW-1:0] reloadVal = '0;
  logic [1:0]    trigSel = 2'b00;
  logic          extTrig = 1'b0;
  logic          running, matchPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  lptimCtl #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .cntRdEn(cntRdEn), .cntRdData(cntRdData), .reloadVal(reloadVal),
    .trigSel(trigSel), .extTrig(extTrig),
    .running(running), .matchPulse(matchPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepClk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic writeCtrl(input logic [31:0] d);
    ctrlWrEn   = 1'b1;
    ctrlWrData = d;
    stepClk(1);
    ctrlWrEn   = 1'b0;
    ctrlWrData = '0;
  endtask

  task automatic testReset();
    chk("R1 ctrl after reset", int'(ctrlRdData), 0);
    chk("R1 count after reset", int'(cntRdData), 0);
    chk("R1 running after reset", int'(running), 0);
  endtask

  task automatic testLocked();
    writeCtrl(32'h0000_001E);
    chk("R2 bits ignored while disabled", int'(ctrlRdData), 0);
    writeCtrl(32'hFFFF_FFFF);
    chk("R2/R1 enable only, reserved zero", int'(ctrlRdData), 1);
    stepClk(2);
    chk("R2 no start from enabling write", int'(running), 0);
    writeCtrl(32'h0);
  endtask

  task automatic testOneShot();
    trigSel = 2'b00; reloadVal = 5;
    writeCtrl(32'h1);
    writeCtrl(32'h3);
    chk("R9 single bit set", int'(ctrlRdData[1]), 1);
    stepClk(1);
    chk("R3 running next cycle", int'(running), 1);
    chk("R9 single bit cleared", int'(ctrlRdData[1]), 0);
    chk("R3 count starts at 0", int'(cntRdData), 0);
    stepClk(5);
    chk("R6 count at reload", int'(cntRdData), 5);
    chk("R6 match pulse", int'(matchPulse), 1);
    stepClk(1);
    chk("R6 stopped", int'(running), 0);
    chk("R6 count zero", int'(cntRdData), 0);
    chk("R6 pulse gone", int'(matchPulse), 0);
  endtask

  task automatic testContAndToSingle();
    reloadVal = 3;
    writeCtrl(32'h5);
    stepClk(1);
    chk("R3 cont running", int'(running), 1);
    stepClk(3);
    chk("R5 match in cont", int'(matchPulse), 1);
    stepClk(1);
    chk("R5 wrap to 0", int'(cntRdData), 0);
    chk("R5 still running", int'(running), 1);
    stepClk(1);
    chk("R5 counting on", int'(cntRdData), 1);
    writeCtrl(32'h3);
    chk("R8 count during request", int'(cntRdData), 2);
    stepClk(1);
    chk("R8 match", int'(matchPulse), 1);
    stepClk(1);
    chk("R8 stopped at match", int'(running), 0);
    writeCtrl(32'h0);
  endtask

  task automatic testSingleToCont();
    reloadVal = 3;
    writeCtrl(32'h1);
    writeCtrl(32'h3);
    stepClk(1);
    writeCtrl(32'h5);
    chk("R7 count", int'(cntRdData), 1);
    stepClk(2);
    chk("R7 match", int'(matchPulse), 1);
    stepClk(1);
    chk("R7 keeps running", int'(running), 1);
    chk("R7 wrapped", int'(cntRdData), 0);
    stepClk(1);
    writeCtrl(32'h0);
    chk("R12 running cleared", int'(running), 0);
    chk("R12 count cleared", int'(cntRdData), 0);
    chk("R12 ctrl cleared", int'(ctrlRdData), 0);
  endtask

  task automatic testTrigger();
    trigSel = 2'b01; reloadVal = 10;
    writeCtrl(32'h1);
    writeCtrl(32'h3);
    stepClk(1);
    chk("R4 armed bit cleared", int'(ctrlRdData[1]), 0);
    chk("R4 not running when armed", int'(running), 0);
    stepClk(3);
    chk("R4 still waiting", int'(running), 0);
    extTrig = 1'b1;
    stepClk(1);
    chk("R4 running after edge", int'(running), 1);
    chk("R4 count 0", int'(cntRdData), 0);
    stepClk(1);
    chk("R4 counting", int'(cntRdData), 1);
    extTrig = 1'b0;
    writeCtrl(32'h0);
    trigSel = 2'b00;
  endtask

  task automatic testBoth();
    reloadVal = 2;
    writeCtrl(32'h1);
    writeCtrl(32'h7);
    stepClk(1);
    stepClk(2);
    chk("R9 both: match", int'(matchPulse), 1);
    stepClk(1);
    chk("R9 both: continuous wins", int'(running), 1);
    writeCtrl(32'h0);
  endtask

  task automatic testCrstAndRar();
    reloadVal = 100;
    writeCtrl(32'h1);
    writeCtrl(32'h5);
    stepClk(10);
    chk("R10 pre count", int'(cntRdData), 9);
    writeCtrl(32'h9);
    chk("R10 bit set", int'(ctrlRdData[3]), 1);
    chk("R10 count after write", int'(cntRdData), 10);
    stepClk(1);
    chk("R10 pending 1", int'(ctrlRdData[3]), 1);
    stepClk(1);
    chk("R10 pending 2 count", int'(cntRdData), 12);
    stepClk(1);
    chk("R10 cleared on third edge", int'(cntRdData), 0);
    chk("R10 bit self-cleared", int'(ctrlRdData[3]), 0);
    stepClk(1);
    chk("R10 counting again", int'(cntRdData), 1);
    writeCtrl(32'h11);
    chk("R11 enable bit set", int'(ctrlRdData[4]), 1);
    cntRdEn = 1'b1;
    #1;
    chk("R11 read value", int'(cntRdData), 2);
    stepClk(1);
    cntRdEn = 1'b0;
    chk("R11 cleared by read", int'(cntRdData), 0);
    stepClk(1);
    chk("R11 counting after read", int'(cntRdData), 1);
    writeCtrl(32'h0);
    chk("R12 rar bit cleared", int'(ctrlRdData), 0);
  endtask

  initial begin
    stepClk(3);
    rstN = 1'b1;
    stepClk(1);
    testReset();
    testLocked();
    testOneShot();
    testContAndToSingle();
    testSingleToCont();
    testTrigger();
    testBoth();
    testCrstAndRar();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule